// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Cell

This block is a small configurable Boolean function generator that sits between signal-routing crossbars. A bank of source signals enters the cell. Four of them are picked by a small input selector and become the operands A, B, C and D. The cell forms four product terms from these operands. In each term, every operand can be taken true or complemented, or replaced by a constant 0 or 1. The terms are ORed together, the result can be inverted, and it is registered so that glitches do not reach the output.

A rising edge on the registered output raises a request line for an interrupt or DMA engine. The request stays high until it is acknowledged. Both configuration registers accept exactly one write after reset and ignore all later writes. A lock bit for each register shows whether that register has been written.

Top module: `aoi_cell`

## Requirements
- R1: After reset, `out_o`, `req_o` and both bits of `lock_o` are 0. Both configuration registers reset to all zeros.
- R2: Each operand in each product term has a 2-bit selector: 00 gives constant 0, 01 gives the operand, 10 gives its complement, and 11 gives constant 1. In the term register (`wr_addr_i`=0), term k, operand i uses bits [8k+2i+1 : 8k+2i], with operand index 0=A, 1=B, 2=C, 3=D.
- R3: Each term is the AND of its four selected literals, and the function is the OR of the four terms. `out_o` shows the function of the `src_i` values present before a clock edge, one edge later.
- R4: Bit 8 of the control register (`wr_addr_i`=1) inverts the function when it is 1.
- R5: Bits [2i+1:2i] of the control register give the index of the `src_i` bit that drives operand i.
- R6: The first write to the term register stores the data and sets `lock_o[0]`. Later writes to it leave the stored value unchanged until reset.
- R7: The first write to the control register stores the data and sets `lock_o[1]`. Later writes to it are ignored until reset. The two registers lock independently of each other.
- R8: An edge that takes `out_o` from 0 to 1 also sets `req_o` at that same edge. `req_o` then stays high while `ack_i` is low.
- R9: `ack_i` high at an edge clears `req_o`. If a new rising output edge happens at that same edge, `req_o` stays set instead.
- R10: A falling output, or an output that stays high, does not set `req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 4 | Source signals for the operand selector |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 1 | 0 selects the term register, 1 selects the control register |
| wr_data_i | input | 32 | Configuration write data |
| ack_i | input | 1 | Request acknowledge |
| out_o | output | 1 | Registered function output |
| req_o | output | 1 | Sticky request, set on a rising output |
| lock_o | output | 2 | Bit 0 is the term register lock, bit 1 is the control register lock |

## Verification
A wrong selector decode, operand route or inversion bit shows up as a wrong `out_o` on the edge after the sources change, so it is caught one cycle after the stimulus. A lock that fails to hold lets a second write change the function. That shows up at `out_o` on the first later input pattern that tells the old function from the new one, and `lock_o` itself shows a bad lock at once. A faulty request flop shows up as `req_o` that differs from a model of rising output edges and acknowledges, checked on every cycle.

// File: rtl/aoi_pkg.sv
package aoi_pkg;
    localparam int NIN = 4;
    localparam int LIT_W = 2;

    typedef enum logic [LIT_W-1:0] {
        LIT_ZERO = 2'b00,
        LIT_TRUE = 2'b01,
        LIT_COMP = 2'b10,
        LIT_ONE  = 2'b11
    } lit_sel_e;
endpackage

// File: rtl/aoi_term.sv
module aoi_term
    import aoi_pkg::*;
(
    input  logic [NIN-1:0]       in_i,
    input  logic [NIN*LIT_W-1:0] sel_i,
    output logic                 prod_o
);
    logic [NIN-1:0] lit;

    for (genvar i = 0; i < NIN; i++) begin : g_lit
        always_comb begin
            unique case (lit_sel_e'(sel_i[i*LIT_W +: LIT_W]))
                LIT_ZERO: lit[i] = 1'b0;
                LIT_TRUE: lit[i] = in_i[i];
                LIT_COMP: lit[i] = ~in_i[i];
                LIT_ONE:  lit[i] = 1'b1;
                default:  lit[i] = 1'b0;
            endcase
        end
    end

    assign prod_o = &lit;
endmodule

// File: rtl/aoi_cfg_regs.sv
module aoi_cfg_regs #(
    parameter int TERM_W = 32,
    parameter int CTL_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [TERM_W-1:0] term_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [1:0]        lock_o
);
    typedef struct packed {
        logic [TERM_W-1:0] term;
        logic [CTL_W-1:0]  ctl;
        logic [1:0]        lock;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            if (!wr_addr_i && !st_q.lock[0]) begin
                st_d.term    = wr_data_i[TERM_W-1:0];
                st_d.lock[0] = 1'b1;
            end else if (wr_addr_i && !st_q.lock[1]) begin
                st_d.ctl     = wr_data_i[CTL_W-1:0];
                st_d.lock[1] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign term_o = st_q.term;
    assign ctl_o  = st_q.ctl;
    assign lock_o = st_q.lock;

    assert_term_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock[0] |=> st_q.lock[0]);
    assert_term_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock[0] |=> $stable(st_q.term));
    assert_ctl_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock[1] |=> ($stable(st_q.ctl) && st_q.lock[1]));
endmodule

// File: rtl/aoi_req.sv
module aoi_req (
    input  logic clk,
    input  logic rst_n,
    input  logic fn_i,
    input  logic ack_i,
    output logic out_o,
    output logic req_o
);
    typedef struct packed {
        logic out;
        logic req;
    } req_st_t;

    req_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.out = fn_i;
        if (ack_i)              st_d.req = 1'b0;
        if (fn_i && !st_q.out)  st_d.req = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = st_q.out;
    assign req_o = st_q.req;

    assert_rise_sets_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.out) |-> st_q.req);
    assert_req_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.req && !ack_i) |=> st_q.req);
    assert_no_spurious_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.req) |-> $rose(st_q.out));
endmodule

// File: rtl/aoi_cell.sv
module aoi_cell
    import aoi_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int NTERM = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  src_i,
    input  logic        wr_en_i,
    input  logic        wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic        ack_i,
    output logic        out_o,
    output logic        req_o,
    output logic [1:0]  lock_o
);
    localparam int SEL_W  = $clog2(NSRC);
    localparam int CTL_W  = NIN * SEL_W + 1;
    localparam int TW     = NIN * LIT_W;
    localparam int TERM_W = NTERM * TW;
    localparam int DATA_W = 32;

    logic [TERM_W-1:0] term_cfg;
    logic [CTL_W-1:0]  ctl_cfg;
    logic [NIN-1:0]    opnd;
    logic [NTERM-1:0]  prod;
    logic              fn;

    aoi_cfg_regs #(.TERM_W(TERM_W), .CTL_W(CTL_W), .DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .term_o    (term_cfg),
        .ctl_o     (ctl_cfg),
        .lock_o    (lock_o)
    );

    for (genvar i = 0; i < NIN; i++) begin : g_opnd
        assign opnd[i] = src_i[ctl_cfg[i*SEL_W +: SEL_W]];
    end

    for (genvar k = 0; k < NTERM; k++) begin : g_term
        aoi_term u_term (
            .in_i   (opnd),
            .sel_i  (term_cfg[k*TW +: TW]),
            .prod_o (prod[k])
        );
    end

    assign fn = (|prod) ^ ctl_cfg[CTL_W-1];

    aoi_req u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .fn_i  (fn),
        .ack_i (ack_i),
        .out_o (out_o),
        .req_o (req_o)
    );

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && ack_i) |=> (!req_o || $rose(out_o)));
endmodule

// File: tb/aoi_cell_tb.sv
`timescale 1ns/1ps
module aoi_cell_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src = '0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        ack = 1'b0;
    logic        out_o, req_o;
    logic [1:0]  lock_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_term;
    logic [8:0]  m_ctl;
    logic [1:0]  m_lock;
    logic        m_out, m_req;

    always #4 clk = ~clk;

    aoi_cell dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .ack_i(ack),
        .out_o(out_o), .req_o(req_o), .lock_o(lock_o)
    );

    function automatic logic lit(input logic [1:0] s, input logic v);
        case (s)
            2'b00: return 1'b0;
            2'b01: return v;
            2'b10: return ~v;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic model(input logic [31:0] t, input logic [8:0] c, input logic [3:0] s);
        logic [3:0] x;
        logic orv = 1'b0;
        for (int i = 0; i < 4; i++) x[i] = s[c[2*i +: 2]];
        for (int k = 0; k < 4; k++) begin
            logic p = 1'b1;
            for (int i = 0; i < 4; i++) p = p & lit(t[8*k + 2*i +: 2], x[i]);
            orv = orv | p;
        end
        return orv ^ c[8];
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; ack = 1'b0; src = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_term = '0; m_ctl = '0; m_lock = '0; m_out = 1'b0; m_req = 1'b0;
        chk(out_o, 0, "R1 out");
        chk(req_o, 0, "R1 req");
        chk(lock_o, 0, "R1 lock");
    endtask

    // called at a negedge; checks at the following negedge
    task automatic step(input logic [3:0] s, input logic a, input logic we,
                        input logic wa, input logic [31:0] wd, input string tag);
        logic e_out, e_req;
        src = s; ack = a; wr_en = we; wr_addr = wa; wr_data = wd;
        e_out = model(m_term, m_ctl, s);
        e_req = (e_out && !m_out) ? 1'b1 : (a ? 1'b0 : m_req);
        m_out = e_out; m_req = e_req;
        if (we) begin
            if (!wa && !m_lock[0]) begin m_term = wd; m_lock[0] = 1'b1; end
            else if (wa && !m_lock[1]) begin m_ctl = wd[8:0]; m_lock[1] = 1'b1; end
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk(out_o, e_out, tag);
        chk(req_o, e_req, "R8 R9 R10 req");
        chk(lock_o, m_lock, "R6 R7 lock");
    endtask

    task automatic cfg(input logic [31:0] t, input logic [8:0] c);
        step(4'h0, 1'b1, 1'b1, 1'b0, t, "R6 write");
        step(4'h0, 1'b1, 1'b1, 1'b1, {23'd0, c}, "R7 write");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R2: operand true, complement, constants
        do_reset();
        cfg(32'h0000_00FD, 9'h0E4);
        step(4'b0001, 1'b0, 1'b0, 1'b0, 0, "R2 true A=1");
        step(4'b0000, 1'b0, 1'b0, 1'b0, 0, "R2 true A=0");
        do_reset();
        cfg(32'h0000_00FE, 9'h0E4);
        step(4'b0000, 1'b0, 1'b0, 1'b0, 0, "R2 comp A=0");
        step(4'b0001, 1'b0, 1'b0, 1'b0, 0, "R2 comp A=1");
        do_reset();
        cfg(32'h0000_00FF, 9'h0E4);
        step(4'b1010, 1'b0, 1'b0, 1'b0, 0, "R2 const one");
        // R4: inversion of an all-zero function
        do_reset();
        cfg(32'h0000_0000, 9'h1E4);
        step(4'b0101, 1'b0, 1'b0, 1'b0, 0, "R4 invert");
        // R5: operand A routed from src[3]
        do_reset();
        cfg(32'h0000_00FD, 9'h0E7);
        step(4'b1000, 1'b0, 1'b0, 1'b0, 0, "R5 src3 high");
        step(4'b0111, 1'b0, 1'b0, 1'b0, 0, "R5 src3 low");
        // R6 / R7: later writes ignored
        step(4'b0111, 1'b0, 1'b1, 1'b0, 32'h0, "R6 rewrite");
        step(4'b0111, 1'b0, 1'b1, 1'b1, 32'h1E4, "R7 rewrite");
        step(4'b1000, 1'b0, 1'b0, 1'b0, 0, "R6 R7 old function kept");
        // R9 / R10 request handling
        step(4'b0000, 1'b1, 1'b0, 1'b0, 0, "R9 ack clears");
        step(4'b1000, 1'b1, 1'b0, 1'b0, 0, "R9 rise beats ack");
        step(4'b1000, 1'b0, 1'b0, 1'b0, 0, "R8 hold");
        step(4'b1000, 1'b1, 1'b0, 1'b0, 0, "R9 ack");
        step(4'b1000, 1'b0, 1'b0, 1'b0, 0, "R10 steady high");
        step(4'b0000, 1'b0, 1'b0, 1'b0, 0, "R10 falling");
        // R3: random configurations and inputs
        for (int c = 0; c < 30; c++) begin
            do_reset();
            step(4'($urandom), 1'($urandom), 1'b0, 1'b0, 0, "R3 pre-config");
            if (($urandom % 2) == 0) begin
                step(4'($urandom), 1'($urandom), 1'b1, 1'b0, $urandom, "R3 cfg");
                step(4'($urandom), 1'($urandom), 1'b1, 1'b1, $urandom, "R3 cfg");
            end else begin
                step(4'($urandom), 1'($urandom), 1'b1, 1'b1, $urandom, "R3 cfg");
                step(4'($urandom), 1'($urandom), 1'b1, 1'b0, $urandom, "R3 cfg");
            end
            for (int n = 0; n < 24; n++)
                step(4'($urandom), 1'(($urandom % 3) == 0), 1'(($urandom % 8) == 0),
                     1'($urandom), $urandom, "R3 random");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule